// File: doc/BRIEF.md
# BT.656 Line Framer

The block turns an 8-bit pixel byte stream into digital video lines framed in the ITU-R BT.656 style. Each line opens with an end-of-active-video (EAV) timing code. A stretch of horizontal blanking follows, filled with the alternating 80h/10h byte pair. Next comes a start-of-active-video (SAV) code, and then a fixed window of 1440 active bytes taken from the input. Each timing code carries the current field and vertical-blanking state together with its protection bits. A receiver uses these codes to recover line, field and frame timing.

The field and vertical-blanking inputs are captured once per line, on the first EAV byte. The SAV that follows therefore reports the same state as its EAV. The line length in clocks comes from an input and is captured at the start of each line, so 1716- and 1728-clock lines both work without a rebuild. A bypass input turns framing off, and raw input bytes then appear on the output. This serves as a test mode. The line counter keeps running in bypass, so framing picks up again at the correct position when bypass is released.

Top module: `bt656_line_framer`

## Requirements
- R1: While rst_ni is low, data_o, code_o and act_o are all 0. The first clock edge after release emits the first byte of an EAV code.
- R2: Every timing code is four consecutive output bytes FFh, 00h, 00h, XY, and code_o is 1 on exactly those four cycles.
- R3: XY is {1, F, V, H, V^H, F^H, F^V, F^V^H}, from bit 7 down to bit 0. H is 1 in EAV and 0 in SAV. For example, F=0 V=0 gives SAV 80h and EAV 9Dh, and F=1 V=1 gives SAV ECh and EAV F1h.
- R4: A line of N clocks (line_len_i, even, at least 1450, captured on the first EAV byte) is laid out in this order: EAV at positions 0 to 3, blanking at positions 4 to N-1445, SAV at positions N-1444 to N-1441, and active bytes at positions N-1440 to N-1. The next line then starts with EAV.
- R5: Blanking bytes alternate 80h, 10h, 80h, ..., starting with 80h right after the EAV.
- R6: During the 1440 active cycles, act_o is 1 and data_o is the data_i byte of the previous cycle. An input of 00h is emitted as 01h, and an input of FFh is emitted as FEh.
- R7: field_i and vblank_i are sampled only on the first EAV byte cycle. The XY bytes of that EAV and of the following SAV both use the sampled values. Changes on these inputs at any other time do not appear in the output.
- R8: While bypass_i is 1, data_o equals data_i one cycle later with no clamping, and code_o and act_o stay 0. The line position keeps advancing, so framed output resumes at the correct position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Byte clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_i | input | 8 | Incoming pixel byte |
| field_i | input | 1 | Field flag: 0 for the first field, 1 for the second |
| vblank_i | input | 1 | 1 on vertical blanking lines |
| bypass_i | input | 1 | Pass raw bytes through with no framing |
| line_len_i | input | CNT_W | Total line length in clocks |
| data_o | output | 8 | Framed output byte |
| code_o | output | 1 | 1 while a timing code byte is on data_o |
| act_o | output | 1 | 1 while an active pixel byte is on data_o |

## Verification
The stimulus drives a ramp that passes through 00h and FFh, so the active window shows whether clamping happens and whether the one-cycle pixel alignment is right. The bench varies line lengths (1450, 1456, 1716) so that the SAV position and blanking length are seen to track the captured length rather than a constant. All four field and vertical-blanking combinations appear, and the flags toggle in mid-line, which shows that the SAV reuses the state captured at EAV. Bypass windows opened in the blanking and active regions show raw passthrough and show that framing resumes in place once bypass is released.

// File: rtl/bt656_framer_pkg.sv
package bt656_framer_pkg;

  localparam int ACTIVE_LEN = 1440;
  localparam int CODE_LEN   = 4;

  localparam logic [7:0] BLANK_EVEN = 8'h80;
  localparam logic [7:0] BLANK_ODD  = 8'h10;

  typedef enum logic [1:0] {
    PH_EAV,
    PH_BLANK,
    PH_SAV,
    PH_ACT
  } phase_e;

  // status byte with protection bits
  function automatic logic [7:0] status_byte(input logic f, input logic v, input logic h);
    return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
  endfunction

  // keep payload out of the reserved code values
  function automatic logic [7:0] clamp_byte(input logic [7:0] b);
    if (b == 8'h00) return 8'h01;
    if (b == 8'hFF) return 8'hFE;
    return b;
  endfunction

endpackage

// File: rtl/lf_line_timer.sv
module lf_line_timer
  import bt656_framer_pkg::*;
#(
  parameter int          CNT_W   = 12,
  parameter logic [11:0] LEN_RST = 12'd1728
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] line_len_i,
  input  logic             field_i,
  input  logic             vblank_i,
  output phase_e           phase_o,
  output logic [1:0]       idx_o,
  output logic             blank_odd_o,
  output logic             field_o,
  output logic             vblank_o
);

  localparam logic [CNT_W-1:0] ACT_OFS = CNT_W'(ACTIVE_LEN);
  localparam logic [CNT_W-1:0] SAV_OFS = CNT_W'(ACTIVE_LEN + CODE_LEN);
  localparam logic [CNT_W-1:0] CODE_END = CNT_W'(CODE_LEN);

  logic [CNT_W-1:0] pos_q, len_q;
  logic             f_q, v_q;
  logic [CNT_W-1:0] sav_start, act_start;
  logic             line_start, line_end;

  assign line_start = (pos_q == '0);
  assign line_end   = (pos_q == len_q - 1'b1);
  assign sav_start  = len_q - SAV_OFS;
  assign act_start  = len_q - ACT_OFS;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q <= '0;
      len_q <= CNT_W'(LEN_RST);
      f_q   <= 1'b0;
      v_q   <= 1'b0;
    end else begin
      pos_q <= line_end ? '0 : pos_q + 1'b1;
      if (line_start) begin
        len_q <= line_len_i;
        f_q   <= field_i;
        v_q   <= vblank_i;
      end
    end
  end

  always_comb begin
    idx_o = pos_q[1:0];
    if (pos_q < CODE_END) begin
      phase_o = PH_EAV;
    end else if (pos_q < sav_start) begin
      phase_o = PH_BLANK;
    end else if (pos_q < act_start) begin
      phase_o = PH_SAV;
      idx_o   = pos_q[1:0] - sav_start[1:0];
    end else begin
      phase_o = PH_ACT;
    end
  end

  assign blank_odd_o = pos_q[0];
  assign field_o     = f_q;
  assign vblank_o    = v_q;

  // R4
  pos_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pos_q < len_q);

  // R7
  flag_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pos_q != CNT_W'(1)) |-> ($stable(f_q) && $stable(v_q)));

endmodule

// File: rtl/lf_byte_mux.sv
module lf_byte_mux
  import bt656_framer_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  phase_e     phase_i,
  input  logic [1:0] idx_i,
  input  logic       blank_odd_i,
  input  logic       field_i,
  input  logic       vblank_i,
  input  logic       bypass_i,
  input  logic [7:0] data_i,
  output logic [7:0] data_o,
  output logic       code_o,
  output logic       act_o
);

  logic [7:0] data_d, data_q;
  logic       code_d, code_q, act_d, act_q;
  logic       live_q;

  always_comb begin
    data_d = data_i;
    code_d = 1'b0;
    act_d  = 1'b0;
    if (!bypass_i) begin
      unique case (phase_i)
        PH_EAV, PH_SAV: begin
          code_d = 1'b1;
          unique case (idx_i)
            2'd0:    data_d = 8'hFF;
            2'd3:    data_d = status_byte(field_i, vblank_i, phase_i == PH_EAV);
            default: data_d = 8'h00;
          endcase
        end
        PH_BLANK: data_d = blank_odd_i ? BLANK_ODD : BLANK_EVEN;
        default: begin
          act_d  = 1'b1;
          data_d = clamp_byte(data_i);
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= 8'h00;
      code_q <= 1'b0;
      act_q  <= 1'b0;
      live_q <= 1'b0;
    end else begin
      data_q <= data_d;
      code_q <= code_d;
      act_q  <= act_d;
      live_q <= 1'b1;
    end
  end

  assign data_o = data_q;
  assign code_o = code_q;
  assign act_o  = act_q;

  // R6
  clamp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_q |-> (data_q != 8'h00 && data_q != 8'hFF));

  // R3
  xy_parity_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code_q && data_q[7] && data_q != 8'hFF) |->
      (data_q[3] == (data_q[5] ^ data_q[4]) && data_q[2] == (data_q[6] ^ data_q[4]) &&
       data_q[1] == (data_q[6] ^ data_q[5]) && data_q[0] == (data_q[6] ^ data_q[5] ^ data_q[4])));

  // R8
  bypass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live_q && $past(bypass_i)) |-> (data_q == $past(data_i) && !code_q && !act_q));

  // R5
  blank_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live_q && !$past(bypass_i) && !code_q && !act_q) |->
      (data_q == BLANK_EVEN || data_q == BLANK_ODD));

  // R2
  code_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(code_q) && !$past(bypass_i) && !$past(bypass_i, 2)) |-> data_q == 8'hFF);

endmodule

// File: rtl/bt656_line_framer.sv
module bt656_line_framer
  import bt656_framer_pkg::*;
#(
  parameter int          CNT_W   = 12,
  parameter logic [11:0] LEN_RST = 12'd1728
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [7:0]       data_i,
  input  logic             field_i,
  input  logic             vblank_i,
  input  logic             bypass_i,
  input  logic [CNT_W-1:0] line_len_i,
  output logic [7:0]       data_o,
  output logic             code_o,
  output logic             act_o
);

  phase_e     phase;
  logic [1:0] idx;
  logic       blank_odd, f_lat, v_lat;

  lf_line_timer #(.CNT_W(CNT_W), .LEN_RST(LEN_RST)) u_timer (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .line_len_i  (line_len_i),
    .field_i     (field_i),
    .vblank_i    (vblank_i),
    .phase_o     (phase),
    .idx_o       (idx),
    .blank_odd_o (blank_odd),
    .field_o     (f_lat),
    .vblank_o    (v_lat)
  );

  lf_byte_mux u_mux (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .phase_i     (phase),
    .idx_i       (idx),
    .blank_odd_i (blank_odd),
    .field_i     (f_lat),
    .vblank_i    (v_lat),
    .bypass_i    (bypass_i),
    .data_i      (data_i),
    .data_o      (data_o),
    .code_o      (code_o),
    .act_o       (act_o)
  );

endmodule

// File: tb/tb_bt656_line_framer.sv
`timescale 1ns/1ps
module tb_bt656_line_framer;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  data_i = '0;
  logic        field_i = 1'b0, vblank_i = 1'b0, bypass_i = 1'b0;
  logic [11:0] line_len_i = 12'd1450;
  logic [7:0]  data_o;
  logic        code_o, act_o;

  int checks = 0, fails = 0;
  logic [9:0] exp_q[$];
  string      tag_q[$];

  int mpos = 0, mlen = 1728, cyc = 0;
  logic mf = 0, mv = 0, first = 1;

  always #4 clk = ~clk;

  bt656_line_framer dut (
    .clk_i(clk), .rst_ni(rst_ni), .data_i(data_i), .field_i(field_i),
    .vblank_i(vblank_i), .bypass_i(bypass_i), .line_len_i(line_len_i),
    .data_o(data_o), .code_o(code_o), .act_o(act_o)
  );

  function automatic logic [7:0] xy(input logic f, input logic v, input logic h);
    return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
  endfunction

  task automatic check(input string tag, input logic [9:0] act, input logic [9:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s data/code/act actual=%h/%b/%b expected=%h/%b/%b",
               tag, act[9:2], act[1], act[0], exp[9:2], exp[1], exp[0]);
    end
  endtask

  // driver: one cycle of stimulus plus its expected output
  task automatic step(input logic [7:0] d, input logic f, input logic v,
                      input logic byp, input logic [11:0] len);
    logic [7:0] eb;
    logic ec, ea;
    string t;
    int k;
    @(negedge clk);
    data_i = d; field_i = f; vblank_i = v; bypass_i = byp; line_len_i = len;
    if (mpos == 0) begin mf = f; mv = v; mlen = int'(len); end
    ec = 0; ea = 0;
    if (byp) begin
      eb = d; t = "R8";
    end else if (mpos < 4) begin
      ec = 1;
      eb = (mpos == 0) ? 8'hFF : (mpos == 3) ? xy(mf, mv, 1'b1) : 8'h00;
      t = (mpos == 3) ? "R3 R7 EAV" : (first ? "R1 R2 EAV" : "R2 EAV");
    end else if (mpos < mlen - 1444) begin
      eb = ((mpos - 4) % 2 == 0) ? 8'h80 : 8'h10; t = "R5";
    end else if (mpos < mlen - 1440) begin
      k = mpos - (mlen - 1444);
      ec = 1;
      eb = (k == 0) ? 8'hFF : (k == 3) ? xy(mf, mv, 1'b0) : 8'h00;
      t = (k == 3) ? "R3 R7 SAV" : "R2 R4 SAV";
    end else begin
      ea = 1;
      eb = (d == 8'h00) ? 8'h01 : (d == 8'hFF) ? 8'hFE : d;
      t = "R4 R6";
    end
    first = 0;
    exp_q.push_back({eb, ec, ea});
    tag_q.push_back(t);
    mpos = (mpos == mlen - 1) ? 0 : mpos + 1;
    cyc++;
  endtask

  task automatic run_line(input logic [11:0] len, input logic f, input logic v,
                          input int flip_at, input int byp_lo, input int byp_hi);
    for (int i = 0; i < int'(len); i++) begin
      logic ff, vv;
      ff = (flip_at >= 0 && i >= flip_at) ? ~f : f;
      vv = (flip_at >= 0 && i >= flip_at) ? ~v : v;
      step(cyc[7:0], ff, vv, (i >= byp_lo && i < byp_hi), len);
    end
  endtask

  // monitor: pops one expected item per clock
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (rst_ni && exp_q.size() > 0)
        check(tag_q.pop_front(), {data_o, code_o, act_o}, exp_q.pop_front());
    end
  end

  task automatic summary;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R4 watchdog actual=running expected=done");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset", {data_o, code_o, act_o}, 10'b0);
    @(posedge clk);
    #2 rst_ni = 1'b1;
    run_line(12'd1450, 1'b0, 1'b1, -1, -1, -1);
    // R7: flags toggle after the EAV sample
    run_line(12'd1456, 1'b1, 1'b0, 10, -1, -1);
    // R8: bypass windows in blanking and in active region
    run_line(12'd1716, 1'b1, 1'b1, -1, 100, 140);
    run_line(12'd1450, 1'b0, 1'b0, 700, 1000, 1010);
    run_line(12'd1728, 1'b1, 1'b0, -1, -1, -1);
    for (int i = 0; i < 4; i++) step(cyc[7:0], 1'b0, 1'b1, 1'b0, 12'd1450);
    repeat (3) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL R4 leftover items actual=%0d expected=0", exp_q.size());
    end
    summary();
  end

endmodule